// File: doc/BRIEF.md
# Adaptive Least-Seen Cluster Test Controller

This block sits in front of a combinational circuit under test. It watches the input words during normal operation and sorts each valid word into one of several disjoint groups of test vectors, called clusters. It keeps one saturating occurrence counter per cluster and always knows which cluster has been seen least often. In normal operation the block passes the input word straight to the circuit.

When the power manager raises the low-power request, the block latches the index of the least-seen cluster. It then drives the circuit, one cycle per vector, with that cluster's stored vectors. When the whole subset has been applied it pulses a done flag. It then raises that cluster's counter above every other counter, so the next idle period tests a different cluster. If the request drops before the subset is complete, the block returns to pass-through at once and leaves the counters unchanged.

Top module: `abist_ctrl`

## Requirements
- R1: After reset all counters are zero, `test_mode_o` and `done_o` are low, and `cut_o` equals `data_i`.
- R2: Outside test mode `cut_o` follows `data_i` in the same cycle. Inside test mode `cut_o` carries the stored vector regardless of `data_i`.
- R3: Vector j (0..VEC_PER_CLUST-1) of cluster c has the value ((c*VEC_PER_CLUST + j)*37 + 11) mod 2^DATA_W. A word with `valid_i` high that equals a vector of cluster c increments counter c at the clock edge. A word that matches no vector, or arrives with `valid_i` low, changes no counter.
- R4: A counter at its maximum value 2^CNT_W-1 stays there on further hits.
- R5: The selected cluster is the one with the smallest counter. Ties go to the lowest index.
- R6: The block samples `lp_req_i` high while in pass-through. It latches the selected index, and from the next cycle it holds `test_mode_o` high and presents vectors j=0,1,... of that cluster, one per cycle, in ascending j.
- R7: In the cycle after the last vector, `done_o` is high for exactly one cycle and `test_mode_o` is low. No new subset starts until `lp_req_i` has been low for at least one cycle.
- R8: On completion, the tested cluster's counter becomes one more than the largest counter value, saturating at 2^CNT_W-1.
- R9: If `lp_req_i` is low at an edge during test mode, test mode ends at that edge. No done pulse follows and no counter changes.
- R10: Valid words arriving while `test_mode_o` is high are not counted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| data_i | input | DATA_W | Functional input word |
| valid_i | input | 1 | Qualifies `data_i` for counting |
| lp_req_i | input | 1 | Low-power or idle request from the power manager |
| cut_o | output | DATA_W | Word driven to the circuit under test |
| test_mode_o | output | 1 | High while stored vectors are applied |
| done_o | output | 1 | One-cycle pulse after a subset completes |

## Verification
The bench builds the block with 8-bit words, four clusters of four vectors and 4-bit counters. This makes the whole input space of 256 words small enough to sweep, both with and without the valid strobe. The 4-bit counters reach saturation after fifteen hits, so wrap-around would change which cluster is chosen next, and that choice is visible on `cut_o`. Back-to-back idle sessions walk the rotation across all four clusters through ties, raises and aborted sessions.

// File: rtl/abist_pkg.sv
package abist_pkg;

  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_TEST = 2'd1,
    ST_HOLD = 2'd2
  } abist_state_e;

  // Odd multiplier keeps every (cluster, index) pair distinct modulo 2^w.
  function automatic int vec_code(input int c, input int j, input int v, input int w);
    return ((c * v + j) * 37 + 11) % (1 << w);
  endfunction

endpackage

// File: rtl/abist_match.sv
module abist_match #(
  parameter int DATA_W        = 8,
  parameter int NUM_CLUST     = 4,
  parameter int VEC_PER_CLUST = 4
) (
  input  logic [DATA_W-1:0]    data_i,
  input  logic                 valid_i,
  output logic [NUM_CLUST-1:0] hit_o
);
  import abist_pkg::*;

  for (genvar c = 0; c < NUM_CLUST; c++) begin : g_clust
    logic [VEC_PER_CLUST-1:0] eq;
    for (genvar j = 0; j < VEC_PER_CLUST; j++) begin : g_vec
      localparam logic [DATA_W-1:0] VecVal = DATA_W'(vec_code(c, j, VEC_PER_CLUST, DATA_W));
      assign eq[j] = (data_i == VecVal);
    end
    assign hit_o[c] = valid_i & (|eq);
  end

endmodule

// File: rtl/abist_counters.sv
module abist_counters #(
  parameter int NUM_CLUST = 4,
  parameter int CNT_W     = 16,
  parameter int IDX_W     = 2
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       inc_en_i,
  input  logic [NUM_CLUST-1:0]       hit_i,
  input  logic                       raise_i,
  input  logic [IDX_W-1:0]           raise_idx_i,
  input  logic [CNT_W-1:0]           raise_val_i,
  output logic [NUM_CLUST*CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] Sat = {CNT_W{1'b1}};

  for (genvar c = 0; c < NUM_CLUST; c++) begin : g_cnt
    logic [CNT_W-1:0] cnt_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cnt_q <= '0;
      end else if (raise_i && (raise_idx_i == IDX_W'(c))) begin
        cnt_q <= raise_val_i;
      end else if (inc_en_i && hit_i[c] && (cnt_q != Sat)) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
    assign cnt_o[c*CNT_W +: CNT_W] = cnt_q;
  end

endmodule

// File: rtl/abist_minmax.sv
module abist_minmax #(
  parameter int NUM_CLUST = 4,
  parameter int CNT_W     = 16,
  parameter int IDX_W     = 2
) (
  input  logic [NUM_CLUST*CNT_W-1:0] cnt_i,
  output logic [IDX_W-1:0]           min_idx_o,
  output logic [CNT_W-1:0]           max_val_o
);
  logic [CNT_W-1:0] min_val;

  always_comb begin
    min_idx_o = '0;
    min_val   = cnt_i[CNT_W-1:0];
    max_val_o = cnt_i[CNT_W-1:0];
    for (int i = 1; i < NUM_CLUST; i++) begin
      // strict compare keeps the lowest index on ties
      if (cnt_i[i*CNT_W +: CNT_W] < min_val) begin
        min_val   = cnt_i[i*CNT_W +: CNT_W];
        min_idx_o = IDX_W'(i);
      end
      if (cnt_i[i*CNT_W +: CNT_W] > max_val_o) begin
        max_val_o = cnt_i[i*CNT_W +: CNT_W];
      end
    end
  end

endmodule

// File: rtl/abist_vecgen.sv
module abist_vecgen #(
  parameter int DATA_W        = 8,
  parameter int NUM_CLUST     = 4,
  parameter int VEC_PER_CLUST = 4,
  parameter int IDX_W         = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              step_i,
  input  logic [IDX_W-1:0]  sel_i,
  output logic [DATA_W-1:0] vec_o,
  output logic              last_o
);
  import abist_pkg::*;

  localparam int ADDR_W = (VEC_PER_CLUST > 1) ? $clog2(VEC_PER_CLUST) : 1;

  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] word [NUM_CLUST];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
    end else if (start_i) begin
      addr_q <= '0;
    end else if (step_i) begin
      addr_q <= addr_q + 1'b1;
    end
  end

  assign last_o = (addr_q == ADDR_W'(VEC_PER_CLUST - 1));

  // One sequential-access store per cluster, contents computed at elaboration.
  for (genvar c = 0; c < NUM_CLUST; c++) begin : g_store
    always_comb begin
      word[c] = '0;
      for (int j = 0; j < VEC_PER_CLUST; j++) begin
        if (addr_q == ADDR_W'(j)) begin
          word[c] = DATA_W'(vec_code(c, j, VEC_PER_CLUST, DATA_W));
        end
      end
    end
  end

  always_comb begin
    vec_o = word[0];
    for (int c = 1; c < NUM_CLUST; c++) begin
      if (sel_i == IDX_W'(c)) vec_o = word[c];
    end
  end

endmodule

// File: rtl/abist_ctrl.sv
module abist_ctrl #(
  parameter int DATA_W        = 8,
  parameter int NUM_CLUST     = 4,
  parameter int VEC_PER_CLUST = 4,
  parameter int CNT_W         = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] data_i,
  input  logic              valid_i,
  input  logic              lp_req_i,
  output logic [DATA_W-1:0] cut_o,
  output logic              test_mode_o,
  output logic              done_o
);
  import abist_pkg::*;

  localparam int IDX_W = (NUM_CLUST > 1) ? $clog2(NUM_CLUST) : 1;
  localparam logic [CNT_W-1:0] Sat = {CNT_W{1'b1}};

  abist_state_e               state_q, state_d;
  logic [IDX_W-1:0]           sel_q;
  logic                       done_q;
  logic [NUM_CLUST-1:0]       hit;
  logic [NUM_CLUST*CNT_W-1:0] cnt;
  logic [IDX_W-1:0]           min_idx;
  logic [CNT_W-1:0]           max_val;
  logic [CNT_W-1:0]           raise_val;
  logic [DATA_W-1:0]          vec;
  logic                       last;
  logic                       in_test, enter, finish;

  assign in_test   = (state_q == ST_TEST);
  assign enter     = (state_q == ST_RUN) && lp_req_i;
  assign finish    = in_test && lp_req_i && last;
  assign raise_val = (max_val == Sat) ? Sat : max_val + 1'b1;

  abist_match #(
    .DATA_W(DATA_W), .NUM_CLUST(NUM_CLUST), .VEC_PER_CLUST(VEC_PER_CLUST)
  ) u_match (
    .data_i (data_i),
    .valid_i(valid_i),
    .hit_o  (hit)
  );

  abist_counters #(
    .NUM_CLUST(NUM_CLUST), .CNT_W(CNT_W), .IDX_W(IDX_W)
  ) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .inc_en_i   (!in_test),
    .hit_i      (hit),
    .raise_i    (finish),
    .raise_idx_i(sel_q),
    .raise_val_i(raise_val),
    .cnt_o      (cnt)
  );

  abist_minmax #(
    .NUM_CLUST(NUM_CLUST), .CNT_W(CNT_W), .IDX_W(IDX_W)
  ) u_minmax (
    .cnt_i    (cnt),
    .min_idx_o(min_idx),
    .max_val_o(max_val)
  );

  abist_vecgen #(
    .DATA_W(DATA_W), .NUM_CLUST(NUM_CLUST), .VEC_PER_CLUST(VEC_PER_CLUST), .IDX_W(IDX_W)
  ) u_vecgen (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(enter),
    .step_i (in_test && lp_req_i),
    .sel_i  (sel_q),
    .vec_o  (vec),
    .last_o (last)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_RUN:  if (lp_req_i) state_d = ST_TEST;
      ST_TEST: begin
        if (!lp_req_i)  state_d = ST_RUN;
        else if (last)  state_d = ST_HOLD;
      end
      ST_HOLD: if (!lp_req_i) state_d = ST_RUN;
      default: state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_RUN;
      sel_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= finish;
      if (enter) sel_q <= min_idx;
    end
  end

  assign test_mode_o = in_test;
  assign cut_o       = in_test ? vec : data_i;
  assign done_o      = done_q;

endmodule

// File: rtl/abist_ctrl_chk.sv
module abist_ctrl_chk #(
  parameter int DATA_W = 8,
  parameter int IDX_W  = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [DATA_W-1:0] data_i,
  input logic              lp_req_i,
  input logic [DATA_W-1:0] cut_o,
  input logic              test_mode_o,
  input logic              done_o,
  input logic [IDX_W-1:0]  sel_q
);

  assert_pass_through_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !test_mode_o |-> cut_o == data_i);

  assert_entry_needs_request_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(test_mode_o) |-> $past(lp_req_i));

  assert_index_held_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    test_mode_o && $past(test_mode_o) |-> $stable(sel_q));

  assert_done_single_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_done_follows_test_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !test_mode_o && $past(test_mode_o));

  assert_abort_exit_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    test_mode_o && !lp_req_i |=> !test_mode_o && !done_o);

endmodule

bind abist_ctrl abist_ctrl_chk #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .data_i     (data_i),
  .lp_req_i   (lp_req_i),
  .cut_o      (cut_o),
  .test_mode_o(test_mode_o),
  .done_o     (done_o),
  .sel_q      (sel_q)
);

// File: tb/test_abist_ctrl.sv
`timescale 1ns/1ps
module test_abist_ctrl;
  localparam int DW = 8;
  localparam int NC = 4;
  localparam int NV = 4;
  localparam int CW = 4;
  localparam int SAT = (1 << CW) - 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [DW-1:0] data = '0;
  logic          valid = 1'b0;
  logic          lp = 1'b0;
  logic [DW-1:0] cut;
  logic          tmode, done;

  int errors = 0;
  int checks = 0;
  int mcnt [NC];
  bit finished = 0;

  always #10 clk = ~clk;

  abist_ctrl #(.DATA_W(DW), .NUM_CLUST(NC), .VEC_PER_CLUST(NV), .CNT_W(CW)) i_abist_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .data_i(data), .valid_i(valid), .lp_req_i(lp),
    .cut_o(cut), .test_mode_o(tmode), .done_o(done)
  );

  function automatic int vec(input int c, input int j);
    return ((c * NV + j) * 37 + 11) % 256;
  endfunction

  function automatic int classify(input int w);
    for (int c = 0; c < NC; c++)
      for (int j = 0; j < NV; j++)
        if (vec(c, j) == w) return c;
    return -1;
  endfunction

  function automatic int argmin();
    int m = 0;
    for (int c = 1; c < NC; c++) if (mcnt[c] < mcnt[m]) m = c;
    return m;
  endfunction

  function automatic int maxcnt();
    int m = mcnt[0];
    for (int c = 1; c < NC; c++) if (mcnt[c] > m) m = mcnt[c];
    return m;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pump(input int c, input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      valid = 1'b1;
      data  = DW'(vec(c, k % NV));
      #1;
      chk(cut == data, "R2 pass-through while pumping", int'(cut), int'(data));
      if (mcnt[c] < SAT) mcnt[c]++;  // R3, R4
    end
    @(negedge clk);
    valid = 1'b0;
  endtask

  // abort_at < 0: run the full subset
  task automatic session(input int abort_at, input int exp_sel);
    int s;
    @(negedge clk);
    valid = 1'b0;
    lp = 1'b1;
    #1;
    s = argmin();
    chk(s == exp_sel, "R5 bench selection trace", s, exp_sel);
    chk(tmode == 1'b0, "R6 no test before sampled request", int'(tmode), 0);
    for (int j = 0; j < NV; j++) begin
      @(negedge clk);
      valid = 1'b1;                              // R10 traffic during test
      data  = DW'(vec((s + 1) % NC, 0));
      #1;
      chk(tmode == 1'b1, "R6 test mode active", int'(tmode), 1);
      chk(int'(cut) == vec(s, j), "R6 R2 vector order from least-seen cluster", int'(cut), vec(s, j));
      chk(done == 1'b0, "R7 no done mid subset", int'(done), 0);
      if (abort_at == j) begin
        lp = 1'b0;
        valid = 1'b0;
        @(negedge clk);
        #1;
        chk(tmode == 1'b0, "R9 abort leaves test mode", int'(tmode), 0);
        chk(done == 1'b0, "R9 abort gives no done", int'(done), 0);
        return;
      end
    end
    @(negedge clk);
    valid = 1'b0;
    #1;
    chk(done == 1'b1, "R7 done after last vector", int'(done), 1);
    chk(tmode == 1'b0, "R7 test mode off with done", int'(tmode), 0);
    mcnt[s] = (maxcnt() >= SAT) ? SAT : maxcnt() + 1;  // R8
    @(negedge clk);
    #1;
    chk(done == 1'b0, "R7 done is one cycle", int'(done), 0);
    chk(tmode == 1'b0, "R7 no restart while request held", int'(tmode), 0);
    lp = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int c = 0; c < NC; c++) mcnt[c] = 0;
    #35;
    rst_n = 1'b1;
    @(negedge clk);
    data = 8'h5A;
    #1;
    chk(tmode == 1'b0, "R1 reset test mode", int'(tmode), 0);
    chk(done == 1'b0, "R1 reset done", int'(done), 0);
    chk(cut == data, "R1 reset pass-through", int'(cut), int'(data));

    // R3 sweep with valid low: nothing counted
    for (int w = 0; w < 256; w++) begin
      @(negedge clk);
      valid = 1'b0;
      data = DW'(w);
      #1;
      chk(cut == data, "R2 pass-through valid low", int'(cut), w);
    end
    // R3 sweep with valid high: each cluster seen NV times, misses uncounted
    for (int w = 0; w < 256; w++) begin
      int c;
      @(negedge clk);
      valid = 1'b1;
      data = DW'(w);
      #1;
      chk(cut == data, "R2 pass-through valid high", int'(cut), w);
      c = classify(w);
      if (c >= 0 && mcnt[c] < SAT) mcnt[c]++;
    end
    @(negedge clk);
    valid = 1'b0;

    // R5 ties to lowest, R8 rotation through all clusters
    session(-1, 0);
    session(-1, 1);
    session(-1, 2);
    session(-1, 3);
    session(-1, 0);
    // R9 abort: counters untouched, same cluster next
    session(2, 1);
    session(0, 1);
    session(-1, 1);
    // R4 saturation: drive three clusters well past the limit
    pump(3, 30);
    pump(1, 30);
    pump(0, 30);
    session(-1, 2);
    session(-1, 0);
    pump(2, 1);
    session(-1, 0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule